// File: doc/BRIEF.md
# Dual-Lane Latch/Register Bus Storage Path

This block is one direction of a registered bus transceiver. An 18-bit bus is split into two 9-bit lanes. Each lane carries eight data bits with a parity bit directly above them. Every bit can work in three ways: as a transparent latch that passes its input straight through, as a latch that holds its value, or as an edge-triggered register. One latch-enable input and one rising-edge clock are shared by both lanes. Each lane also has its own active-low clock enable, so the two lanes can be captured independently.

The stored or passed value goes out on the output bus under an active-low output enable. The tri-state pad is modelled as plain data plus an active-high drive flag. While the output is not driven, the data lines read zero. The storage is a clocked register with a bypass multiplexer in front of the output. While latch enable is high, the output follows the input in the same cycle, and every clock edge also loads the register. When latch enable drops, the output then holds the input seen at the last edge while latch enable was still high. A synchronous reset clears the stored bits.

Top module: `bus_store_cell`

## Requirements
- R1: While `out_en_n` is 1, `drive_en` is 0 and every bit of `dout` is 0, whatever the other inputs are.
- R2: While `out_en_n` is 0 and `latch_en` is 1, `dout` equals `din` in the same cycle, including changes of `din` between clock edges.
- R3: On a rising clock edge with `latch_en` 0 and `clk_en_n[k]` 0, lane k stores its slice of `din`, and the stored value appears on `dout` after that edge.
- R4: On a rising clock edge with `latch_en` 0 and `clk_en_n[k]` 1, lane k keeps its stored value.
- R5: While `latch_en` is 0, `dout` does not change between clock edges, even if `din` changes.
- R6: After `latch_en` falls, `dout` shows the `din` value that was present at the last clock edge while `latch_en` was 1. This holds even when both clock enables are 1.
- R7: The lanes are independent. Lane 0 is `din[8:0]`/`dout[8:0]` and lane 1 is `din[17:9]`/`dout[17:9]`. Bit 8 of each lane is its parity bit. `clk_en_n[k]` gates lane k only.
- R8: A rising edge with `rst` 1 clears all stored bits to 0.
- R9: `drive_en` always equals the inverse of `out_en_n`. Storage keeps loading and holding while the output is disabled, and the stored value reappears when the output is enabled again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| latch_en | input | 1 | Transparent mode select, active high |
| clk_en_n | input | 2 | Per-lane clock enable, active low, bit k for lane k |
| out_en_n | input | 1 | Output enable, active low |
| din | input | 18 | Input bus, two 9-bit lanes |
| dout | output | 18 | Output bus data, zero when not driven |
| drive_en | output | 1 | High when the output bus is driven |

## Verification
Transparency and capture can coincide. A clock edge that arrives while latch enable is high both passes `din` to the output and loads the register, and only the following latch-enable fall shows whether that load happened. The bench provokes this by opening the latch with both clock enables deasserted, moving `din` between edges, and then dropping latch enable. It then checks that the output holds the value sampled at the last open edge, not the pre-latch stored value. Output disable combined with capture is judged the same way: a value loaded while the output is disabled must appear when the output is enabled again.

// File: rtl/bsc_pkg.sv
package bsc_pkg;

  // Operating mode of one storage lane for the current cycle.
  typedef enum logic [1:0] {
    MODE_PASS  = 2'd0,  // transparent: output follows input, edge also loads
    MODE_HOLD  = 2'd1,  // closed latch / disabled register
    MODE_CLOCK = 2'd2   // register loads on the rising edge
  } store_mode_e;

  // Decide the mode from the shared latch enable and the lane clock enable.
  // Latch enable wins over the clock enable.
  function automatic store_mode_e mode_of(input logic le, input logic ce_n);
    if (le)         return MODE_PASS;
    else if (!ce_n) return MODE_CLOCK;
    else            return MODE_HOLD;
  endfunction

  // A lane register loads on the edge in every mode except hold.
  function automatic logic mode_loads(input store_mode_e m);
    return (m != MODE_HOLD);
  endfunction

  // The output shows the live input only in pass mode.
  function automatic logic mode_passes(input store_mode_e m);
    return (m == MODE_PASS);
  endfunction

endpackage

// File: rtl/bsc_lane_store.sv
module bsc_lane_store
  import bsc_pkg::*;
#(
  parameter int WIDTH = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             le,
  input  logic             ce_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q,
  output logic             load_evt,
  output logic             pass_evt
);

  store_mode_e mode;

  always_comb begin
    mode     = mode_of(le, ce_n);
    load_evt = mode_loads(mode);
    pass_evt = mode_passes(mode);
  end

  always_ff @(posedge clk) begin
    if (rst)           q <= '0;
    else if (load_evt) q <= d;
  end

  // R3
  capture_chk: assert property (@(posedge clk) disable iff (rst)
    load_evt |=> (q == $past(d)));

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!le && ce_n) |=> $stable(q));

endmodule

// File: rtl/bsc_bypass_mux.sv
module bsc_bypass_mux #(
  parameter int WIDTH = 9
) (
  input  logic             pass,
  input  logic [WIDTH-1:0] live,
  input  logic [WIDTH-1:0] held,
  output logic [WIDTH-1:0] sel_out
);

  always_comb sel_out = pass ? live : held;

endmodule

// File: rtl/bsc_out_gate.sv
module bsc_out_gate #(
  parameter int WIDTH = 18
) (
  input  logic             oe_n,
  input  logic [WIDTH-1:0] val,
  output logic [WIDTH-1:0] bus,
  output logic             drv
);

  always_comb begin
    drv = ~oe_n;
    bus = drv ? val : '0;
  end

endmodule

// File: rtl/bus_store_cell.sv
module bus_store_cell
  import bsc_pkg::*;
#(
  parameter int LANES     = 2,
  parameter int DATA_BITS = 8
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                latch_en,
  input  logic [LANES-1:0]                    clk_en_n,
  input  logic                                out_en_n,
  input  logic [LANES*(DATA_BITS+1)-1:0]      din,
  output logic [LANES*(DATA_BITS+1)-1:0]      dout,
  output logic                                drive_en
);

  localparam int LANE_W = DATA_BITS + 1;
  localparam int BUS_W  = LANES * LANE_W;

  logic [BUS_W-1:0] held_bus;
  logic [BUS_W-1:0] view_bus;
  logic [LANES-1:0] load_evt;
  logic [LANES-1:0] pass_evt;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    bsc_lane_store #(.WIDTH(LANE_W)) u_store (
      .clk      (clk),
      .rst      (rst),
      .le       (latch_en),
      .ce_n     (clk_en_n[k]),
      .d        (din[k*LANE_W +: LANE_W]),
      .q        (held_bus[k*LANE_W +: LANE_W]),
      .load_evt (load_evt[k]),
      .pass_evt (pass_evt[k])
    );

    bsc_bypass_mux #(.WIDTH(LANE_W)) u_mux (
      .pass    (pass_evt[k]),
      .live    (din[k*LANE_W +: LANE_W]),
      .held    (held_bus[k*LANE_W +: LANE_W]),
      .sel_out (view_bus[k*LANE_W +: LANE_W])
    );
  end

  bsc_out_gate #(.WIDTH(BUS_W)) u_gate (
    .oe_n (out_en_n),
    .val  (view_bus),
    .bus  (dout),
    .drv  (drive_en)
  );

  // R1
  undriven_chk: assert property (@(posedge clk) disable iff (rst)
    out_en_n |-> (!drive_en && dout == '0));

  // R2
  transparent_chk: assert property (@(posedge clk) disable iff (rst)
    (drive_en && latch_en) |-> (dout == din));

  // R6
  latch_close_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(latch_en) && drive_en && !$past(rst)) |-> (dout == $past(din)));

  // R9
  drive_flag_chk: assert property (@(posedge clk) disable iff (rst)
    drive_en != out_en_n);

endmodule

// File: tb/bus_store_cell_bench.sv
module bus_store_cell_bench;

  localparam int CLK_PERIOD = 10;
  localparam int LANES = 2;
  localparam int LW    = 9;
  localparam int BW    = LANES * LW;

  logic          clk = 1'b0;
  logic          rst;
  logic          le;
  logic [1:0]    cen;
  logic          oen;
  logic [BW-1:0] din;
  logic [BW-1:0] dout;
  logic          drv;

  int n_run  = 0;
  int n_fail = 0;
  bit checking = 0;
  bit done = 0;

  logic [LW-1:0] model [LANES];

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_store_cell u_bus_store_cell (
    .clk(clk), .rst(rst), .latch_en(le), .clk_en_n(cen),
    .out_en_n(oen), .din(din), .dout(dout), .drive_en(drv)
  );

  // Behavioural reference: one stored word per lane.
  always @(posedge clk) begin
    for (int k = 0; k < LANES; k++) begin
      if (rst) model[k] = '0;
      else if (le || !cen[k]) model[k] = din[k*LW +: LW];
    end
  end

  function automatic logic [BW-1:0] expect_bus();
    logic [BW-1:0] e;
    for (int k = 0; k < LANES; k++) e[k*LW +: LW] = model[k];
    if (le) e = din;
    if (oen) e = '0;
    return e;
  endfunction

  task automatic check(input string tag, input logic [BW-1:0] got, input logic [BW-1:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  // Per-cycle comparison against the reference.
  always @(negedge clk) begin
    if (checking) begin
      check(oen ? "R1" : (le ? "R2" : "R3"), dout, expect_bus());
      check("R9", {{(BW-1){1'b0}}, drv}, {{(BW-1){1'b0}}, ~oen});
    end
  end

  task automatic drive(input logic l, input logic [1:0] c, input logic o, input logic [BW-1:0] d);
    @(posedge clk); #1;
    le = l; cen = c; oen = o; din = d;
  endtask

  localparam logic [BW-1:0] VA = 18'h15A3C;
  localparam logic [BW-1:0] VB = 18'h2C1E7;
  localparam logic [BW-1:0] VC = 18'h3FFFF;
  localparam logic [BW-1:0] VD = 18'h0F0F1;
  localparam logic [BW-1:0] VE = 18'h31234;
  localparam logic [BW-1:0] VF = 18'h00155;
  localparam logic [BW-1:0] VG = 18'h2AAAA;
  localparam logic [BW-1:0] VH = 18'h01001;

  initial begin
    rst = 1'b1; le = 1'b0; cen = 2'b11; oen = 1'b0; din = '0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0; checking = 1;
    @(negedge clk) check("R8 reset state", dout, '0);

    // Capture both lanes; before the edge the output stays put.
    drive(0, 2'b00, 0, VA);
    @(negedge clk) check("R5 no edge yet", dout, '0);
    @(negedge clk) check("R3 capture", dout, VA);

    // Lane 0 enabled, lane 1 held.
    drive(0, 2'b10, 0, VB);
    @(negedge clk); @(negedge clk) check("R7 lane split", dout, {VA[17:9], VB[8:0]});
    drive(0, 2'b11, 0, VC);
    @(negedge clk); @(negedge clk) check("R4 hold", dout, {VA[17:9], VB[8:0]});

    // Transparent with both clock enables off, din moves mid-cycle.
    drive(1, 2'b11, 0, VD);
    @(negedge clk) check("R2 pass", dout, VD);
    #1 din = VE;
    #1 check("R2 pass mid-cycle", dout, VE);
    drive(0, 2'b11, 0, VF);
    @(negedge clk) check("R6 latch close", dout, VE);
    #1 din = VC;
    #1 check("R5 closed mid-cycle", dout, VE);

    // Disabled output still captures.
    drive(0, 2'b00, 1, VG);
    @(negedge clk) check("R1 undriven", dout, '0);
    check("R1 flag", {{(BW-1){1'b0}}, drv}, '0);
    drive(0, 2'b11, 0, VH);
    @(negedge clk) check("R9 retained", dout, VG);

    // Random traffic compared every cycle.
    for (int i = 0; i < 400; i++) begin
      drive(1'($urandom_range(0, 3) == 0), 2'($urandom), 1'($urandom_range(0, 5) == 0),
            BW'($urandom));
    end

    // Reset mid-run.
    drive(0, 2'b00, 0, VC);
    @(posedge clk); #1;
    rst = 1'b1;
    @(posedge clk); #1;
    rst = 1'b0; cen = 2'b11;
    @(negedge clk) check("R8 mid reset", dout, '0);

    checking = 0;
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule